// File: doc/BRIEF.md
# HDLC Zero-Insertion Frame Transmitter

This block turns frames into a synchronous HDLC line stream, one line bit for each pulse of `bit_en`. The pulse comes from an external bit clock. Frames arrive one byte at a time on a valid/ready stream, and `in_last` marks the final byte. The first two bytes of a frame are its address and control fields. The payload follows them. The block treats all of these bytes the same way and sends each one least significant bit first.

Each frame begins with a flag. The frame bytes follow, then the ones' complement of a 16-bit CRC over those bytes, then a closing flag. The block inserts a zero after every run of five ones between the flags, including runs inside the CRC. Flags themselves never get an inserted zero. When no frame is waiting, the line carries flags back to back. The closing flag of one frame also serves as the opening flag of a frame that is ready in time.

The upstream source is paced directly by the line. A byte is taken only in a cycle where a line bit goes out and the transmitter needs a new byte.

Top module: `hdlc_stuff_tx`

## Requirements
- R1: `tx_bit` is 1 after reset and changes only in the cycle after a cycle with `bit_en` high. Each `bit_en` pulse puts out exactly one line bit.
- R2: While no frame is pending, the line repeats the flag 0x7E, sent least significant bit first (0, six 1s, 0), starting with the first bit after reset.
- R3: Between the opening and the closing flag, a 0 is inserted after any five consecutive 1s, and this includes the CRC bits. The count of 1s restarts after each inserted 0 and after each flag. A flag never has a 0 inserted into it.
- R4: A frame on the line is an opening flag, then the accepted bytes in order (address, control, payload), each sent least significant bit first, then the check field, then a closing flag.
- R5: `in_ready` is high only in a cycle with `bit_en` high in which the framer needs its next byte. That is the last bit of a flag, or the last bit of a byte that was not marked last. `in_ready` is never high in a cycle that sends an inserted 0. A byte is accepted when `in_valid` and `in_ready` are both high.
- R6: The check field is a CRC-16 with polynomial x^16+x^12+x^5+1, preset to 0xFFFF and run over the bytes least significant bit first (reflected form, 0x8408). Its ones' complement is sent least significant bit first.
- R7: A frame ends with the byte accepted with `in_last` high. If the next frame's first byte is valid at the end of the closing flag, that flag also opens the next frame, so exactly one flag separates the two frames.
- R8: If `in_valid` is low when a flag ends, at least one further full flag is sent before the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One line bit is sent in each cycle where this is high |
| in_data | input | DATA_W | Frame byte |
| in_valid | input | 1 | `in_data` and `in_last` hold a byte |
| in_last | input | 1 | The byte is the last one of its frame |
| in_ready | output | 1 | The byte offered this cycle is taken |
| tx_bit | output | 1 | Serial HDLC line bit |

## Verification
Two events can fall on the same bit time: the byte handshake and a pending inserted zero. This happens when a run of five ones ends exactly on a byte boundary. The bench provokes it with frames of 0xFF bytes and with random data biased toward 0xFF. It also picks, by search, a two-byte frame whose check field itself needs a zero inserted. The bench decodes the captured line independently, stripping zeros and finding flags. The collision is judged by requiring that no handshake falls on any bit the decoder strips, and that every decoded byte and CRC matches the bench's own computation.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int FLAG_LEN = 8;
  localparam logic [FLAG_LEN-1:0] FLAG_PAT = 8'h7E;

  typedef enum logic [1:0] {
    ST_FLAG = 2'd0,
    ST_DATA = 2'd1,
    ST_FCS  = 2'd2
  } tx_st_e;
endpackage

// File: rtl/hdlc_crc16.sv
module hdlc_crc16 #(
  parameter int               W        = 16,
  parameter logic [W-1:0]     POLY_REV = 16'h8408,
  parameter logic [W-1:0]     INIT     = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         upd,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] crc_q
);
  logic [W-1:0] crc_d;
  logic         fb;

  always_comb begin
    fb    = crc_q[0] ^ din;
    crc_d = crc_q;
    if (init) begin
      crc_d = INIT;
    end else if (upd) begin
      crc_d = (crc_q >> 1) ^ (fb ? POLY_REV : '0);
    end else if (shift) begin
      crc_d = crc_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= INIT;
    else        crc_q <= crc_d;
  end
endmodule

// File: rtl/hdlc_zero_ins.sv
module hdlc_zero_ins #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic src_bit,
  input  logic src_body,
  output logic adv,
  output logic ins,
  output logic tx_bit
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);

  logic [CW-1:0] ones_q, ones_d;
  logic          tx_d;

  always_comb begin
    ins    = (ones_q == RUN_MAX);
    adv    = bit_en && !ins;
    ones_d = ones_q;
    tx_d   = tx_bit;
    if (bit_en) begin
      if (ins) begin
        tx_d   = 1'b0;
        ones_d = '0;
      end else begin
        tx_d = src_bit;
        if (!src_body || !src_bit) ones_d = '0;
        else                       ones_d = ones_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      tx_bit <= 1'b1;
    end else begin
      ones_q <= ones_d;
      tx_bit <= tx_d;
    end
  end
endmodule

// File: rtl/hdlc_frame_seq.sv
module hdlc_frame_seq
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              crc_lsb,
  output logic              in_ready,
  output logic              src_bit,
  output logic              src_body,
  output logic              crc_init,
  output logic              crc_upd,
  output logic              crc_shift,
  output logic              crc_din
);
  localparam int SPAN0 = (CRC_W > DATA_W) ? CRC_W : DATA_W;
  localparam int SPAN  = (SPAN0 > FLAG_LEN) ? SPAN0 : FLAG_LEN;
  localparam int IW    = $clog2(SPAN);
  localparam int FW    = $clog2(FLAG_LEN);
  localparam logic [IW-1:0] BYTE_END = IW'(DATA_W - 1);
  localparam logic [IW-1:0] FCS_END  = IW'(CRC_W - 1);
  localparam logic [IW-1:0] FLAG_END = IW'(FLAG_LEN - 1);

  tx_st_e            st_q, st_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              last_q, last_d;
  logic              want, take;

  always_comb begin
    want     = (st_q == ST_FLAG && idx_q == FLAG_END) ||
               (st_q == ST_DATA && idx_q == BYTE_END && !last_q);
    in_ready = adv && want;
    take     = in_ready && in_valid;
    src_body = (st_q != ST_FLAG);
    case (st_q)
      ST_FLAG: src_bit = FLAG_PAT[idx_q[FW-1:0]];
      ST_DATA: src_bit = sh_q[0];
      default: src_bit = ~crc_lsb;
    endcase
    crc_init  = take && (st_q == ST_FLAG);
    crc_upd   = adv && (st_q == ST_DATA);
    crc_shift = adv && (st_q == ST_FCS);
    crc_din   = sh_q[0];
  end

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    last_d = last_q;
    if (adv) begin
      case (st_q)
        ST_FLAG: begin
          if (idx_q == FLAG_END) begin
            idx_d = '0;
            if (take) begin
              st_d   = ST_DATA;
              sh_d   = in_data;
              last_d = in_last;
            end
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        ST_DATA: begin
          sh_d = sh_q >> 1;
          if (idx_q == BYTE_END) begin
            idx_d = '0;
            if (take) begin
              sh_d   = in_data;
              last_d = in_last;
            end else begin
              st_d = ST_FCS;
            end
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        ST_FCS: begin
          if (idx_q == FCS_END) begin
            idx_d = '0;
            st_d  = ST_FLAG;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        default: begin
          st_d  = ST_FLAG;
          idx_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FLAG;
      idx_q  <= '0;
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/hdlc_stuff_tx.sv
module hdlc_stuff_tx #(
  parameter int                DATA_W       = 8,
  parameter int                RUN_LEN      = 5,
  parameter int                CRC_W        = 16,
  parameter logic [CRC_W-1:0]  CRC_POLY_REV = 16'h8408,
  parameter logic [CRC_W-1:0]  CRC_INIT     = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              tx_bit
);
  logic             adv, ins_w, src_bit, src_body;
  logic             crc_init, crc_upd, crc_shift, crc_din;
  logic [CRC_W-1:0] crc_q;

  hdlc_frame_seq #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .crc_lsb(crc_q[0]), .in_ready(in_ready),
    .src_bit(src_bit), .src_body(src_body),
    .crc_init(crc_init), .crc_upd(crc_upd), .crc_shift(crc_shift),
    .crc_din(crc_din)
  );

  hdlc_crc16 #(.W(CRC_W), .POLY_REV(CRC_POLY_REV), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .upd(crc_upd),
    .shift(crc_shift), .din(crc_din), .crc_q(crc_q)
  );

  hdlc_zero_ins #(.RUN_LEN(RUN_LEN)) u_stuff (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .src_bit(src_bit), .src_body(src_body),
    .adv(adv), .ins(ins_w), .tx_bit(tx_bit)
  );
endmodule

// File: rtl/hdlc_stuff_tx_chk.sv
module hdlc_stuff_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic in_ready,
  input logic ins,
  input logic tx_bit
);
  logic       tick_q;
  logic [2:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      run_q  <= 3'd0;
    end else begin
      tick_q <= bit_en;
      if (tick_q) run_q <= tx_bit ? ((run_q == 3'd7) ? 3'd7 : run_q + 3'd1) : 3'd0;
    end
  end

  p_line_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));
  p_ready_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bit_en);
  p_ready_not_ins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !ins);
  p_ins_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ins) |=> !tx_bit);
  p_run_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 3'd6);
endmodule

bind hdlc_stuff_tx hdlc_stuff_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_ready(in_ready),
  .ins(ins_w), .tx_bit(tx_bit)
);

// File: tb/test_hdlc_stuff_tx.sv
module test_hdlc_stuff_tx;
  localparam int NF   = 12;
  localparam int NL   = 8192;

  logic       clk, rst_n, bit_en, in_valid, in_last, in_ready, tx_bit;
  logic [7:0] in_data;

  hdlc_stuff_tx i_hdlc_stuff_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready), .tx_bit(tx_bit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int   total, bad;
  logic [7:0] fb [0:255];
  int   flen [0:NF-1];
  int   foff [0:NF-1];
  int   gap  [0:NF-1];
  logic line [0:NL-1];
  logic hsl  [0:NL-1];
  int   nl;
  int   ready_bad, hs_on_stuff, nstuff, fcs_stuff;
  logic finished;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fcs_of(input int k);
    logic [15:0] c;
    logic [7:0]  b;
    c = 16'hFFFF;
    for (int n = 0; n < flen[k]; n++) begin
      b = fb[foff[k] + n];
      for (int i = 0; i < 8; i++) begin
        if (c[0] ^ b[i]) c = (c >> 1) ^ 16'h8408;
        else             c = c >> 1;
      end
    end
    return ~c;
  endfunction

  function automatic logic has_run5(input logic [15:0] v);
    for (int i = 0; i <= 11; i++) if (v[i +: 5] == 5'h1F) return 1'b1;
    return 1'b0;
  endfunction

  task automatic finish_frame(input logic body[0:1023], input int L, inout int fi,
                              input int nfl, input int maxdrop);
    logic [15:0] got, exp_f;
    logic [7:0]  gb;
    if (fi >= NF) begin
      chk(1'b0, "R7 extra frame", fi, NF - 1);
      return;
    end
    chk(L == (flen[fi] + 2) * 8, "R4 frame length bits", L, (flen[fi] + 2) * 8);
    if (L == (flen[fi] + 2) * 8) begin
      for (int n = 0; n < flen[fi]; n++) begin
        for (int i = 0; i < 8; i++) gb[i] = body[n * 8 + i];
        chk(gb == fb[foff[fi] + n], "R4 byte", int'(gb), int'(fb[foff[fi] + n]));
      end
      for (int i = 0; i < 16; i++) got[i] = body[flen[fi] * 8 + i];
      exp_f = fcs_of(fi);
      chk(got == exp_f, "R6 check field", int'(got), int'(exp_f));
      if (maxdrop >= L - 15) fcs_stuff++;
    end
    if (gap[fi] == 0 && fi > 0) chk(nfl == 0, "R7 shared flag, idle flags", nfl, 0);
    else                        chk(nfl >= 1, "R8 idle flag before frame", nfl, 1);
    fi++;
  endtask

  task automatic decode();
    logic body [0:1023];
    int ones, bl, fi, nfl, maxdrop, mism;
    ones = 0; bl = 0; fi = 0; nfl = 0; maxdrop = -1; mism = 0;
    for (int i = 0; i < 64; i++) if (line[i] !== hdlc_tx_pkg::FLAG_PAT[i % 8]) mism++;
    chk(mism == 0 && nl >= 64, "R2 idle flags after reset", mism, 0);
    for (int i = 0; i < nl; i++) begin
      if (line[i]) begin
        ones++;
        if (bl < 1024) body[bl] = 1'b1;
        bl++;
        if (ones == 7) chk(1'b0, "R3 run of ones", ones, 6);
      end else if (ones == 5) begin
        ones = 0; nstuff++; maxdrop = bl;
        if (hsl[i]) hs_on_stuff++;
      end else if (ones == 6) begin
        ones = 0;
        bl = bl - 7;
        if (bl > 0) begin
          finish_frame(body, bl, fi, nfl, maxdrop);
          nfl = 0;
        end else begin
          nfl++;
        end
        bl = 0; maxdrop = -1;
      end else begin
        ones = 0;
        if (bl < 1024) body[bl] = 1'b0;
        bl++;
      end
    end
    chk(fi == NF, "R7 frames decoded", fi, NF);
    chk(nstuff > 0, "R3 inserted zeros seen", nstuff, 1);
    chk(fcs_stuff > 0, "R3 zero inserted in check field", fcs_stuff, 1);
    chk(hs_on_stuff == 0, "R5 handshake on inserted zero", hs_on_stuff, 0);
    chk(ready_bad == 0, "R5 ready without bit_en", ready_bad, 0);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int k, j, gcnt, drain, off, seed;
    logic tick_prev, hs_prev, held;
    logic [15:0] f;
    total = 0; bad = 0; nl = 0; finished = 1'b0;
    ready_bad = 0; hs_on_stuff = 0; nstuff = 0; fcs_stuff = 0;
    seed = $urandom(32'd4711);
    // frame 0: all ones, long idle before it
    off = 0;
    flen[0] = 6; foff[0] = 0; gap[0] = 80;
    for (int n = 0; n < 6; n++) fb[n] = 8'hFF;
    off = 6;
    // frame 1: two bytes whose check field needs an inserted zero
    flen[1] = 2; foff[1] = off; gap[1] = 0;
    fb[off + 1] = 8'h03;
    for (int a = 0; a < 256; a++) begin
      fb[off] = 8'(a);
      f = fcs_of(1);
      if (has_run5(f)) break;
    end
    off += 2;
    for (int fr = 2; fr < NF; fr++) begin
      flen[fr] = 2 + int'($urandom % 13);
      foff[fr] = off;
      gap[fr]  = ($urandom % 2 == 0) ? 0 : 48 + int'($urandom % 32);
      for (int n = 0; n < flen[fr]; n++)
        fb[off + n] = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
      off += flen[fr];
    end

    rst_n = 1'b0; bit_en = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_bit === 1'b1, "R1 reset line value", int'(tx_bit), 1);
    chk(in_ready === 1'b0, "R5 ready low at reset", int'(in_ready), 0);
    held = 1'b1;
    repeat (10) begin
      @(negedge clk);
      if (tx_bit !== 1'b1) held = 1'b0;
    end
    chk(held, "R1 line holds without bit_en", int'(held), 1);

    k = 0; j = 0; gcnt = 0; drain = 0; tick_prev = 1'b0; hs_prev = 1'b0;
    while (drain < 400) begin
      @(negedge clk);
      if (tick_prev && nl < NL) begin
        line[nl] = tx_bit; hsl[nl] = hs_prev; nl++;
      end
      if (hs_prev) begin
        j++;
        if (j == flen[k]) begin k++; j = 0; gcnt = 0; end
      end
      if (k == NF) drain++;
      bit_en = ($urandom % 4) != 0;
      if (k < NF && gcnt >= gap[k]) begin
        in_valid = 1'b1;
        in_data  = fb[foff[k] + j];
        in_last  = (j == flen[k] - 1);
      end else begin
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (bit_en && k < NF) gcnt++;
      end
      #1;
      if (in_ready && !bit_en) ready_bad++;
      hs_prev   = in_ready && in_valid;
      tick_prev = bit_en;
    end
    bit_en = 1'b0; in_valid = 1'b0;
    decode();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule